// File: doc/BRIEF.md
# DDR3 Write Leveling Sequencer

This block runs write leveling for a single DDR3 rank from the controller side. A one-cycle `start` pulse makes it write mode register 1 with the leveling-enable bit set and the output-disable bit cleared. It then waits out the mode-register settle time, raises on-die termination, waits for termination to take effect, and drives the strobe low as a preamble. After that it fires single strobe pulses, one at a time.

After each pulse the sequencer waits for the feedback settle time and samples the DQ bit that the memory returns. It then moves a per-lane strobe delay code up or down by one step. The code locks once a sampled 0 is followed by a sampled 1 one step higher, which is where the memory clock goes from low to high. On exit the block drops termination and the strobe drive, writes mode register 1 again with leveling cleared, and pulses `done` with the locked code and an error flag. The flag is set if the code reached either end of its range without finding the edge.

Every wait is a clock-cycle count given by a parameter. The analog delay line, the pads and the memory's power-up initialization sit outside this block.

Top module: `wl_leveler`

## Requirements
- R1: In reset and when idle, `cmd` is DES (code 0), `odt`, `dqs_oe`, `dqs` and `done` are low, `err` is low after reset, and `dly_code` equals `CODE_INIT` (8 by default).
- R2: A `start` pulse in idle produces exactly one MRS command (code 2). It has `mrs_bank` = 1, `mrs_data` bit 7 = 1 and bit 12 = 0, and all other bits equal to `MR1_BASE`.
- R3: From the entry MRS up to the exit MRS, every command in between is NOP (code 1).
- R4: `odt` rises no earlier than `T_MOD` cycles after the entry MRS cycle. `dqs_oe` first rises no earlier than `T_ODTLON` cycles after `odt` rises and no earlier than `T_WLDQSEN` cycles after the entry MRS.
- R5: The strobe is held driven low for at least max(`T_WPRE`, `T_WLMRD`) cycles before its first high. Each high lasts exactly `T_DQSH` cycles. `dqs` is high only while `dqs_oe` is high, and `dqs_n` is always its complement.
- R6: The feedback bit is sampled only after the strobe has been low for more than `T_WLO` full cycles following a pulse.
- R7: A sampled 0 raises the code by one. A sampled 1 with no earlier 0 in the run lowers it by one. A sampled 1 after an earlier 0 locks the current code. The code changes by at most one step per cycle.
- R8: A sampled 0 at the top code (2^`CW`−1), or a sampled 1 at code 0, ends the run with `err` high and the code left where it stopped.
- R9: On exit, `odt` and `dqs_oe` are low before and during the exit MRS. That MRS has bit 7 = 0 and bit 12 = 0. It is followed by a one-cycle `done` pulse, and `dly_code` and `err` stay held after it until the next start.
- R10: A `start` pulse while a run is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to level the rank |
| dq_fb | input | 1 | Feedback DQ bit returned by the memory |
| done | output | 1 | One-cycle pulse when the run ends |
| err | output | 1 | Run ended without finding the clock edge |
| cmd | output | 2 | Command: 0 DES, 1 NOP, 2 MRS |
| mrs_bank | output | 2 | Mode register index during MRS (1), else 0 |
| mrs_data | output | 16 | Mode register payload during MRS, else 0 |
| odt | output | 1 | On-die termination enable |
| dqs_oe | output | 1 | Strobe drive enable |
| dqs | output | 1 | Strobe true level |
| dqs_n | output | 1 | Strobe complement level |
| dly_code | output | CW | Strobe delay code for the lane |

## Verification
The bench models the memory as a clock edge at a chosen code, and the feedback it returns is inverted until the settle time after each pulse has passed. A design that samples too early therefore locks at the wrong code or flags an error. The edge positions include ones above, at and below the start code, next to both ends of the range, and out of range on both sides. These catch a design that locks on the first 1, never turns from downward to upward search, or steps past the end of the range instead of flagging it. Interval measurements from the entry MRS to termination, to strobe drive and to the first pulse catch shortened waits. Watching the command bus catches a stray non-NOP command or an exit write issued while termination is still on. A second start during a run, and a reset during a run, catch a block that restarts or keeps leveling state.

// File: rtl/wl_pkg.sv
package wl_pkg;

    typedef enum logic [1:0] {
        CMD_DES = 2'd0,
        CMD_NOP = 2'd1,
        CMD_MRS = 2'd2
    } wl_cmd_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ENTER,
        S_MOD,
        S_ODT,
        S_DQSEN,
        S_PRE,
        S_HIGH,
        S_LOW,
        S_SAMPLE,
        S_DROP,
        S_EXIT,
        S_DONE
    } wl_state_e;

    localparam int LVL_BIT  = 7;
    localparam int QOFF_BIT = 12;
    localparam logic [1:0] MR1_IDX = 2'd1;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wl_cycle_timer.sv
module wl_cycle_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/wl_code_walker.sv
module wl_code_walker #(
    parameter int CW   = 4,
    parameter int INIT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic          up,
    input  logic          dn,
    output logic [CW-1:0] code,
    output logic          at_max,
    output logic          at_min
);
    localparam logic [CW-1:0] INIT_C = CW'(INIT);

    logic [CW-1:0] code_d, code_q;

    assign at_max = (code_q == '1);
    assign at_min = (code_q == '0);

    always_comb begin
        code_d = code_q;
        if (reload)
            code_d = INIT_C;
        else if (up && !at_max)
            code_d = code_q + 1'b1;
        else if (dn && !at_min)
            code_d = code_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= INIT_C;
        else        code_q <= code_d;
    end

    assign code = code_q;
endmodule

// File: rtl/wl_leveler.sv
module wl_leveler
    import wl_pkg::*;
#(
    parameter int          CW        = 4,
    parameter int          CODE_INIT = 8,
    parameter int          T_MOD     = 12,
    parameter int          T_ODTLON  = 4,
    parameter int          T_WLDQSEN = 25,
    parameter int          T_WLMRD   = 40,
    parameter int          T_WPRE    = 2,
    parameter int          T_DQSH    = 2,
    parameter int          T_DQSL    = 2,
    parameter int          T_WLO     = 6,
    parameter logic [15:0] MR1_BASE  = 16'h0044
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dq_fb,
    output logic          done,
    output logic          err,
    output logic [1:0]    cmd,
    output logic [1:0]    mrs_bank,
    output logic [15:0]   mrs_data,
    output logic          odt,
    output logic          dqs_oe,
    output logic          dqs,
    output logic          dqs_n,
    output logic [CW-1:0] dly_code
);
    // Derived durations, each at least one cycle
    localparam int PRE_CYC = imax(imax(T_WPRE, T_WLMRD), 1);
    localparam int LOW_CYC = imax(imax(T_WLO, T_DQSL), 1);
    localparam int MOD_CYC = imax(T_MOD, 1);
    localparam int ON_CYC  = imax(T_ODTLON, 1);
    localparam int EN_CYC  = imax(T_WLDQSEN, 1);
    localparam int HI_CYC  = imax(T_DQSH, 1);
    localparam int MAXD    = imax(imax(imax(PRE_CYC, LOW_CYC), imax(MOD_CYC, ON_CYC)),
                                  imax(EN_CYC, HI_CYC));
    localparam int TW      = $clog2(MAXD + 1);

    localparam logic [15:0] LVL_MASK  = 16'(1) << LVL_BIT;
    localparam logic [15:0] QOFF_MASK = 16'(1) << QOFF_BIT;
    localparam logic [15:0] MR1_ENTER = (MR1_BASE & ~QOFF_MASK) | LVL_MASK;
    localparam logic [15:0] MR1_LEAVE = MR1_BASE & ~QOFF_MASK & ~LVL_MASK;

    typedef struct packed {
        wl_state_e st;
        logic      pzero;
        logic      err;
    } regs_t;

    regs_t r_d, r_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          step_up, step_dn, code_reload;
    logic          at_max, at_min;

    wl_cycle_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    wl_code_walker #(.CW(CW), .INIT(CODE_INIT)) u_code (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (code_reload),
        .up     (step_up),
        .dn     (step_dn),
        .code   (dly_code),
        .at_max (at_max),
        .at_min (at_min)
    );

    always_comb begin
        r_d         = r_q;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        step_up     = 1'b0;
        step_dn     = 1'b0;
        code_reload = 1'b0;
        case (r_q.st)
            S_IDLE: if (start) begin
                r_d.st      = S_ENTER;
                r_d.err     = 1'b0;
                r_d.pzero   = 1'b0;
                code_reload = 1'b1;
            end
            S_ENTER: begin
                r_d.st   = S_MOD;
                tmr_load = 1'b1;
                tmr_val  = TW'(MOD_CYC - 1);
            end
            S_MOD: if (tmr_zero) begin
                r_d.st   = S_ODT;
                tmr_load = 1'b1;
                tmr_val  = TW'(ON_CYC - 1);
            end
            S_ODT: if (tmr_zero) begin
                r_d.st   = S_DQSEN;
                tmr_load = 1'b1;
                tmr_val  = TW'(EN_CYC - 1);
            end
            S_DQSEN: if (tmr_zero) begin
                r_d.st   = S_PRE;
                tmr_load = 1'b1;
                tmr_val  = TW'(PRE_CYC - 1);
            end
            S_PRE: if (tmr_zero) begin
                r_d.st   = S_HIGH;
                tmr_load = 1'b1;
                tmr_val  = TW'(HI_CYC - 1);
            end
            S_HIGH: if (tmr_zero) begin
                r_d.st   = S_LOW;
                tmr_load = 1'b1;
                tmr_val  = TW'(LOW_CYC - 1);
            end
            S_LOW: if (tmr_zero) r_d.st = S_SAMPLE;
            S_SAMPLE: begin
                if (dq_fb) begin
                    if (r_q.pzero) begin
                        r_d.st = S_DROP;
                    end else if (at_min) begin
                        r_d.err = 1'b1;
                        r_d.st  = S_DROP;
                    end else begin
                        step_dn  = 1'b1;
                        r_d.st   = S_HIGH;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(HI_CYC - 1);
                    end
                end else begin
                    r_d.pzero = 1'b1;
                    if (at_max) begin
                        r_d.err = 1'b1;
                        r_d.st  = S_DROP;
                    end else begin
                        step_up  = 1'b1;
                        r_d.st   = S_HIGH;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(HI_CYC - 1);
                    end
                end
            end
            S_DROP:  r_d.st = S_EXIT;
            S_EXIT:  r_d.st = S_DONE;
            S_DONE:  r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: S_IDLE, pzero: 1'b0, err: 1'b0};
        else        r_q <= r_d;
    end

    // Output decode from registered state
    wl_cmd_e cmd_e;
    always_comb begin
        case (r_q.st)
            S_IDLE, S_DONE:  cmd_e = CMD_DES;
            S_ENTER, S_EXIT: cmd_e = CMD_MRS;
            default:         cmd_e = CMD_NOP;
        endcase
    end

    assign cmd      = cmd_e;
    assign mrs_bank = (cmd_e == CMD_MRS) ? MR1_IDX : 2'd0;
    assign mrs_data = (r_q.st == S_ENTER) ? MR1_ENTER :
                      (r_q.st == S_EXIT)  ? MR1_LEAVE : 16'h0000;
    assign odt      = (r_q.st == S_ODT) || (r_q.st == S_DQSEN) || (r_q.st == S_PRE) ||
                      (r_q.st == S_HIGH) || (r_q.st == S_LOW) || (r_q.st == S_SAMPLE);
    assign dqs_oe   = (r_q.st == S_PRE) || (r_q.st == S_HIGH) ||
                      (r_q.st == S_LOW) || (r_q.st == S_SAMPLE);
    assign dqs      = (r_q.st == S_HIGH);
    assign dqs_n    = ~dqs;
    assign done     = (r_q.st == S_DONE);
    assign err      = r_q.err;
endmodule

// File: rtl/wl_seq_chk.sv
module wl_seq_chk
    import wl_pkg::*;
#(
    parameter int CW    = 4,
    parameter int T_MOD = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cmd,
    input logic [1:0]    mrs_bank,
    input logic [15:0]   mrs_data,
    input logic          odt,
    input logic          dqs_oe,
    input logic          dqs,
    input logic          done,
    input logic [CW-1:0] dly_code
);
    logic        in_lvl_q;
    logic [15:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_lvl_q <= 1'b0;
            since_q  <= '0;
        end else begin
            if (cmd == CMD_MRS) begin
                in_lvl_q <= mrs_data[LVL_BIT];
                since_q  <= '0;
            end else if (since_q != '1) begin
                since_q  <= since_q + 1'b1;
            end
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_DES) |-> (!odt && !dqs_oe && !dqs));

    p_enter_payload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS && !in_lvl_q) |->
            (mrs_data[LVL_BIT] && !mrs_data[QOFF_BIT] && mrs_bank == MR1_IDX));

    p_nop_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_lvl_q && cmd != CMD_MRS) |-> (cmd == CMD_NOP));

    p_odt_after_mod_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(odt) |-> (since_q >= 16'(T_MOD)));

    p_dqs_needs_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dqs |-> dqs_oe);

    p_code_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_lvl_q && $past(in_lvl_q)) |->
            ({1'b0, dly_code} == {1'b0, $past(dly_code)} ||
             {1'b0, dly_code} == {1'b0, $past(dly_code)} + 1'b1 ||
             {1'b0, dly_code} + 1'b1 == {1'b0, $past(dly_code)}));

    p_drop_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS && in_lvl_q) |->
            (!odt && !dqs_oe && !mrs_data[LVL_BIT] && !mrs_data[QOFF_BIT]));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind wl_leveler wl_seq_chk #(.CW(CW), .T_MOD(T_MOD)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .mrs_bank (mrs_bank),
    .mrs_data (mrs_data),
    .odt      (odt),
    .dqs_oe   (dqs_oe),
    .dqs      (dqs),
    .done     (done),
    .dly_code (dly_code)
);

// File: tb/wl_leveler_tb.sv
module wl_leveler_tb;
    localparam int          CW        = 4;
    localparam int          CODE_INIT = 8;
    localparam int          T_MOD     = 12;
    localparam int          T_ODTLON  = 4;
    localparam int          T_WLDQSEN = 25;
    localparam int          T_WLMRD   = 40;
    localparam int          T_WPRE    = 2;
    localparam int          T_DQSH    = 2;
    localparam int          T_DQSL    = 2;
    localparam int          T_WLO     = 6;
    localparam logic [15:0] MR1B      = 16'h0044;
    localparam int          PRE_MIN   = (T_WLMRD > T_WPRE) ? T_WLMRD : T_WPRE;
    localparam logic [15:0] KEEP_MASK = ~((16'(1) << 7) | (16'(1) << 12));

    // {knee[4:0], expected code[3:0], expected err, expected pulses[4:0]}
    localparam int NV = 9;
    localparam logic [14:0] VEC [NV] = '{
        {5'd3,  4'd3,  1'b0, 5'd8},
        {5'd8,  4'd8,  1'b0, 5'd3},
        {5'd9,  4'd9,  1'b0, 5'd2},
        {5'd12, 4'd12, 1'b0, 5'd5},
        {5'd15, 4'd15, 1'b0, 5'd8},
        {5'd1,  4'd1,  1'b0, 5'd10},
        {5'd0,  4'd0,  1'b1, 5'd9},
        {5'd16, 4'd15, 1'b1, 5'd8},
        {5'd5,  4'd5,  1'b0, 5'd6}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          dq_fb;
    logic          done, err, odt, dqs_oe, dqs, dqs_n;
    logic [1:0]    cmd, mrs_bank;
    logic [15:0]   mrs_data;
    logic [CW-1:0] dly_code;

    always #10 clk = ~clk;

    wl_leveler #(
        .CW(CW), .CODE_INIT(CODE_INIT), .T_MOD(T_MOD), .T_ODTLON(T_ODTLON),
        .T_WLDQSEN(T_WLDQSEN), .T_WLMRD(T_WLMRD), .T_WPRE(T_WPRE),
        .T_DQSH(T_DQSH), .T_DQSL(T_DQSL), .T_WLO(T_WLO), .MR1_BASE(MR1B)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dq_fb(dq_fb),
        .done(done), .err(err), .cmd(cmd), .mrs_bank(mrs_bank),
        .mrs_data(mrs_data), .odt(odt), .dqs_oe(dqs_oe), .dqs(dqs),
        .dqs_n(dqs_n), .dly_code(dly_code)
    );

    // Memory model: edge at code "knee"; feedback wrong until settled
    logic [4:0] knee = 5'd0;
    int lowcnt = 0;
    logic truth;
    assign truth = ({1'b0, dly_code} >= knee);
    assign dq_fb = (lowcnt >= T_WLO + 1) ? truth : ~truth;

    int checks = 0, fails = 0;
    int cyc = 0, n_enter = 0, n_exit = 0, bad_pay = 0, bad_nop = 0, bad_drop = 0;
    int bad_hi = 0, bad_cpl = 0, hi_run = 0, pulses = 0, done_cnt = 0;
    int enter_cyc = 0, odt_rise = 0, oe_rise = 0, first_hi = 0;
    logic in_lvl = 1'b0, odt_p = 1'b0, oe_p = 1'b0, dqs_p = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            in_lvl = 1'b0;
        end else begin
            if (cmd == 2'd2) begin
                if (mrs_bank != 2'd1 || mrs_data[12] ||
                    ((mrs_data & KEEP_MASK) != (MR1B & KEEP_MASK))) bad_pay++;
                if (mrs_data[7]) begin
                    n_enter++; enter_cyc = cyc; in_lvl = 1'b1;
                end else begin
                    n_exit++; in_lvl = 1'b0;
                    if (odt || dqs_oe) bad_drop++;
                end
            end else if (in_lvl && cmd != 2'd1) begin
                bad_nop++;
            end
            if (odt && !odt_p) odt_rise = cyc;
            if (dqs_oe && !oe_p) oe_rise = cyc;
            if (dqs && !dqs_p) begin
                pulses++;
                if (pulses == 1) first_hi = cyc;
            end
            if (dqs && !dqs_oe) bad_hi++;
            if (dqs_n === dqs) bad_cpl++;
            if (dqs) hi_run++;
            else begin
                if (dqs_p && hi_run != T_DQSH) bad_hi++;
                hi_run = 0;
            end
            if (dqs_oe && !dqs) lowcnt++; else lowcnt = 0;
            if (done) done_cnt++;
        end
        odt_p = odt; oe_p = dqs_oe; dqs_p = dqs;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input int act, input int lim);
        checks++;
        if (act < lim) begin
            fails++;
            $display("FAIL %s: actual %0d expected at least %0d", req, act, lim);
        end
    endtask

    task automatic clear_mon();
        n_enter = 0; n_exit = 0; bad_pay = 0; bad_nop = 0; bad_drop = 0;
        bad_hi = 0; bad_cpl = 0; pulses = 0; done_cnt = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // Wait for done; returns code and err seen with it
    task automatic wait_done(output int code_o, output int err_o, output bit ok);
        ok = 1'b0; code_o = -1; err_o = -1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) begin
                ok = 1'b1; code_o = int'(dly_code); err_o = int'(err);
                break;
            end
        end
    endtask

    task automatic check_run(input int exp_code, input int exp_err, input int exp_pulses);
        int c, e;
        bit ok;
        wait_done(c, e, ok);
        chk("R9 done reached", int'(ok), 1);
        chk("R7 locked code", c, exp_code);
        chk("R8 error flag", e, exp_err);
        chk("R6/R7 pulse count", pulses, exp_pulses);
        repeat (3) @(negedge clk);
        chk("R9 code held", int'(dly_code), exp_code);
        chk("R9 err held", int'(err), exp_err);
        chk("R9 done one cycle", done_cnt, 1);
        chk("R9 one exit MRS", n_exit, 1);
        chk("R9 drop before exit", bad_drop, 0);
        chk("R2 one entry MRS", n_enter, 1);
        chk("R2 payload", bad_pay, 0);
        chk("R3 NOP window", bad_nop, 0);
        chk_ge("R4 odt after tMOD", odt_rise - enter_cyc, T_MOD);
        chk_ge("R4 drive after ODTLon", oe_rise - odt_rise, T_ODTLON);
        chk_ge("R4 drive after tWLDQSEN", oe_rise - enter_cyc, T_WLDQSEN);
        chk_ge("R5 preamble", first_hi - oe_rise, PRE_MIN);
        chk("R5 pulse width and enable", bad_hi, 0);
        chk("R5 complement", bad_cpl, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int c, e;
        bit ok;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cmd DES in reset", int'(cmd), 0);
        chk("R1 code init in reset", int'(dly_code), CODE_INIT);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle cmd", int'(cmd), 0);
        chk("R1 idle odt/oe/dqs/done", int'({odt, dqs_oe, dqs, done}), 0);
        chk("R1 idle err", int'(err), 0);
        chk("R1 idle code", int'(dly_code), CODE_INIT);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            knee = VEC[v][14:10];
            clear_mon();
            pulse_start();
            check_run(int'(VEC[v][9:6]), int'(VEC[v][5]), int'(VEC[v][4:0]));
        end

        // R10: start during a run is ignored
        knee = 5'd10;
        clear_mon();
        pulse_start();
        repeat (30) @(negedge clk);
        pulse_start();
        repeat (60) @(negedge clk);
        pulse_start();
        check_run(10, 0, 3);
        chk("R10 no second entry", n_enter, 1);

        // R1: reset mid-run returns to idle
        knee = 5'd2;
        clear_mon();
        pulse_start();
        repeat (70) @(negedge clk);
        chk("R1 run active before reset", int'(dqs_oe), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-run quiet", int'({odt, dqs_oe, dqs, done}), 0);
        chk("R1 reset mid-run cmd", int'(cmd), 0);
        chk("R1 reset mid-run code", int'(dly_code), CODE_INIT);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 stays idle after reset", int'(cmd), 0);

        // Run after reset still works (knee below init)
        clear_mon();
        pulse_start();
        wait_done(c, e, ok);
        chk("R7 lock after reset", c, 2);
        chk("R8 no error after reset", e, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule